// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus (I2C-compatible). A host uses it to read and write a small file of 8-bit registers held inside the block. The serial clock and data lines are oversampled by the system clock. The full contents of the register file are always visible to neighbouring logic on one wide parallel output.

A host write opens with a start condition and the device address byte. It then sends a pointer byte, followed by any number of data bytes that land at the pointer. A read is split into two transfers. The first is a write that carries only the pointer byte and then a stop. The second opens with a new start and the read address, and the block streams register contents from the pointer back to the host. Bit 0 of register 10 chooses how the pointer moves after each data byte. When it is 0 the pointer steps forward. When it is 1 the pointer stays where it is.

The controller is a single state machine with these states:
- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address byte. It moves to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` drives the acknowledge. At the end of the ninth clock it goes to `ST_RDATA` for a read or to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_PTR_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, which returns to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` goes back to `ST_RDATA` when the host acknowledges, or to `ST_IGNORE` on a not-acknowledge.
- A stop sends every state to `ST_IDLE`. A start sends every state to `ST_ADDR`.

Top module: `regbus_i2c_slave`

## Requirements
- R1: Bits are only taken after a start condition, which is the data line falling while the clock line is high. Bytes clocked with no start are not acknowledged. A stop condition, which is the data line rising while the clock line is high, returns the slave to idle.
- R2: An address byte of 8'h54 (write) or 8'h55 (read) is acknowledged by driving the data line low during the ninth clock-high period. The address is in bits 7..1 and the direction flag is in bit 0, where 1 means read.
- R3: An address byte with any other 7-bit address gets no acknowledge. All later bytes are ignored until the next start or stop: no acknowledge is given and no register changes.
- R4: In a write transfer, the first byte after the address loads the pointer. Each following byte is stored in the register the pointer selects. Every byte the host sends is acknowledged.
- R5: While bit 0 of register 10 is 0, which is its reset value, the pointer steps by one after each data byte written or read.
- R6: While bit 0 of register 10 is 1, the pointer does not move, so repeated data bytes all access one register. The step decision for a byte uses the mode value held before that byte is written.
- R7: A read transfer returns register contents most significant bit first. It starts at the pointer left by an earlier pointer-only write.
- R8: During a read the slave releases the data line for the host's acknowledge bit. A host not-acknowledge ends the read, and the slave leaves the data line released until the next start.
- R9: The pointer uses the low log2(NUM_REGS) bits of the pointer byte. It wraps from NUM_REGS-1 to 0.
- R10: All registers reset to zero. Register i appears on `reg_out[8*i+7:8*i]`.
- R11: The data-line drive changes only while the synchronized clock line is low.
- R12: A start that arrives in the middle of a transfer, with no stop before it, restarts the address phase. A read opened this way continues from the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the data line is pulled low (open drain) |
| reg_out | output | NUM_REGS*8 | Flattened contents of all registers |

## Verification
The bench targets the following corner cases:
- **Foreign address.** A design that acknowledged a foreign address would pull the line low in the ninth clock. A design that only ignored the address byte would then store the bytes that follow it.
- **Mode bit changing inside a transfer.** Writing the mode bit in the middle of a transfer checks that the step uses the old mode value. A design that used the new value would place the following byte one register too low.
- **Pointer wrap.** A write that runs past the last register checks the wrap back to zero.
- **Read after not-acknowledge.** Clocking a further byte after the host's not-acknowledge shows whether the slave keeps driving. A design that kept driving would return anything other than all ones.
- **Repeated start.** A repeated start straight after a held-pointer write must read back the register that was just written.

// File: rtl/regbus_i2c_pkg.sv
package regbus_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/regbus_i2c_linemon.sv
// Two-flop synchronizer for both bus lines plus edge and condition detection.
module regbus_i2c_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, stg1, stg2, prev;

    assign raw = {scl_in, sda_in};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg1[g] <= 1'b1;
                    stg2[g] <= 1'b1;
                    prev[g] <= 1'b1;
                end else begin
                    stg1[g] <= raw[g];
                    stg2[g] <= stg1[g];
                    prev[g] <= stg2[g];
                end
            end
        end
    endgenerate

    assign scl_s     = stg2[1];
    assign sda_s     = stg2[0];
    assign scl_rise  = stg2[1] & ~prev[1];
    assign scl_fall  = ~stg2[1] & prev[1];
    assign start_det = stg2[1] & prev[1] & prev[0] & ~stg2[0];
    assign stop_det  = stg2[1] & prev[1] & ~prev[0] & stg2[0];

endmodule

// File: rtl/regbus_i2c_regfile.sv
// Register file with one write port, one read port and a flat view of all registers.
module regbus_i2c_regfile #(
    parameter int NUM_REGS = 16,
    localparam int PTR_W = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] flat_out
);
    logic [7:0] regs [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= 8'h00;
                else if (wr_en && wr_idx == PTR_W'(g))
                    regs[g] <= wr_data;
            end
            assign flat_out[g*8 +: 8] = regs[g];
        end
    endgenerate

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/regbus_i2c_slave.sv
module regbus_i2c_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 16,
    parameter int         MODE_IDX = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_out
);
    import regbus_i2c_pkg::*;

    localparam int PTR_W = $clog2(NUM_REGS);
    localparam int BITS  = 8;

    slv_state_e       state, nxt;
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]       cnt;
    logic [7:0]       sr, tx, rd_data;
    logic [PTR_W-1:0] ptr;
    logic             rw, mack, wr_en, byte_end, addr_hit, mode_hold;

    regbus_i2c_linemon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    regbus_i2c_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (ptr),
        .wr_data  (sr),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .flat_out (reg_out)
    );

    assign mode_hold = reg_out[MODE_IDX*8];
    assign byte_end  = scl_fall && (cnt == 4'(BITS));
    assign addr_hit  = (sr[7:1] == DEV_ADDR);
    assign wr_en     = (state == ST_WDATA) && byte_end;

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det)
            nxt = ST_IDLE;
        else if (start_det)
            nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_end) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = mack ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sr     <= '0;
            tx     <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_det || start_det) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        sr  <= {sr[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end
                    if (byte_end) begin
                        cnt    <= '0;
                        sda_oe <= (state != ST_ADDR) || addr_hit;
                        if (state == ST_ADDR)
                            rw <= sr[0];
                        else if (state == ST_PTR)
                            ptr <= sr[PTR_W-1:0];
                        else if (!mode_hold)
                            ptr <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall)
                        sda_oe <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise)
                        cnt <= cnt + 4'd1;
                    if (scl_fall) begin
                        if (cnt == 4'(BITS)) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            if (!mode_hold)
                                ptr <= ptr + 1'b1;
                        end else begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise)
                        mack <= ~sda_s;
                    if (scl_fall && mack) begin
                        cnt    <= '0;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regbus_i2c_slave_chk.sv
module regbus_i2c_slave_chk #(
    parameter int PTR_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_s,
    input logic                       sda_oe,
    input regbus_i2c_pkg::slv_state_e state,
    input logic                       wr_en,
    input logic                       mode_hold,
    input logic [PTR_W-1:0]           ptr
);
    import regbus_i2c_pkg::*;

    // R11: drive changes only follow a cycle with the clock line low
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R3: no drive while ignoring the bus
    a_r3_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R1: no drive while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R2: outside a read byte, drive only appears in an acknowledge slot
    a_r2_drive_in_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && state != ST_RDATA) |->
            (state == ST_ADDR_ACK || state == ST_PTR_ACK || state == ST_WDATA_ACK));

    // R5: stepping mode advances the pointer after a stored byte
    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_hold) |=> ptr == $past(ptr) + 1'b1);

    // R6: hold mode leaves the pointer in place
    a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_hold) |=> $stable(ptr));

endmodule

bind regbus_i2c_slave regbus_i2c_slave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .state     (state),
    .wr_en     (wr_en),
    .mode_hold (mode_hold),
    .ptr       (ptr)
);

// File: tb/regbus_i2c_slave_test.sv
`timescale 1ns/1ps
module regbus_i2c_slave_test;
    localparam int NREG = 16;
    localparam int MIDX = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] reg_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mreg [NREG];
    int mptr = 0;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    regbus_i2c_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (m_scl),
        .sda_in  (sda_line),
        .sda_oe  (sda_oe),
        .reg_out (reg_out)
    );

    // every-clock monitor of R11 against the bench's own clock line
    logic prev_oe = 1'b0;
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            checks++;
            if (sda_oe !== prev_oe && m_scl === 1'b1) begin
                errors++;
                $display("FAIL R11 drive changed while clock high: act=%b exp=%b", sda_oe, prev_oe);
            end
            prev_oe = sda_oe;
        end
    end

    task automatic half(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(string tag);
        for (int i = 0; i < NREG; i++)
            chk(tag, reg_out[i*8 +: 8], mreg[i]);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half(5);
        m_scl = 1'b1; half(10);
        m_sda = 1'b0; half(10);
        m_scl = 1'b0; half(5);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half(5);
        m_scl = 1'b1; half(10);
        m_sda = 1'b1; half(10);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; half(5);
            m_scl = 1'b1; half(10);
            m_scl = 1'b0; half(5);
        end
        m_sda = 1'b1; half(5);
        m_scl = 1'b1; half(5);
        acked = (sda_line == 1'b0);
        half(5);
        m_scl = 1'b0; half(5);
    endtask

    task automatic read_byte(logic give_ack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; half(5);
            m_scl = 1'b1; half(5);
            d = {d[6:0], sda_line};
            half(5);
            m_scl = 1'b0; half(5);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; half(5);
        m_scl = 1'b1; half(10);
        m_scl = 1'b0; half(5);
    endtask

    // model step after one data byte
    task automatic model_step();
        if (mreg[MIDX][0] == 1'b0) mptr = (mptr + 1) % NREG;
    endtask

    task automatic write_seq(logic [7:0] p, logic [7:0] data[$], string tag);
        logic a;
        bus_start();
        send_byte(8'h54, a); chk({tag, " R2 write address ack"}, {7'd0, a}, 8'd1);
        send_byte(p, a);     chk({tag, " R4 pointer ack"}, {7'd0, a}, 8'd1);
        mptr = p % NREG;
        foreach (data[k]) begin
            logic hold;
            hold = mreg[MIDX][0];
            send_byte(data[k], a);
            chk({tag, " R4 data ack"}, {7'd0, a}, 8'd1);
            mreg[mptr] = data[k];
            if (!hold) mptr = (mptr + 1) % NREG;
        end
        bus_stop();
        chk_regs({tag, " R4 register contents"});
    endtask

    task automatic read_seq(logic [7:0] p, int n, string tag);
        logic a;
        logic [7:0] d;
        logic [7:0] q[$];
        write_seq(p, q, tag);
        bus_start();
        send_byte(8'h55, a); chk({tag, " R2 read address ack"}, {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            read_byte(k != n - 1, d);
            chk({tag, " R7 read data"}, d, mreg[mptr]);
            model_step();
        end
        bus_stop();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] d;
        logic [7:0] q[$];
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        half(5);
        rst_n = 1'b1;
        half(5);

        // R10: reset state
        chk_regs("R10 reset value");
        chk("R10 no drive after reset", {7'd0, sda_oe}, 8'd0);

        // R1: byte without a start condition
        m_scl = 1'b0; half(5);
        send_byte(8'h54, a);
        chk("R1 no ack without start", {7'd0, a}, 8'd0);

        // R3: foreign address, following bytes ignored
        bus_start();
        send_byte(8'h50, a); chk("R3 foreign address nack", {7'd0, a}, 8'd0);
        send_byte(8'h02, a); chk("R3 later byte nack", {7'd0, a}, 8'd0);
        send_byte(8'hEE, a); chk("R3 data ignored nack", {7'd0, a}, 8'd0);
        bus_stop();
        chk_regs("R3 registers unchanged");

        // R4/R5: multi-byte stepping write
        q = '{8'hA1, 8'hB2, 8'hC3};
        write_seq(8'h02, q, "R5 step write");

        // R1: after stop, bytes without a new start are ignored
        m_scl = 1'b0; half(5);
        send_byte(8'h54, a);
        chk("R1 idle after stop", {7'd0, a}, 8'd0);

        // R7: pointer-only write then read with stepping
        read_seq(8'h03, 3, "R7 read");

        // R8: after host nack the slave stays released
        bus_start();
        send_byte(8'h55, a); chk("R2 read address ack", {7'd0, a}, 8'd1);
        read_byte(1'b0, d);  chk("R8 first byte", d, mreg[mptr]);
        model_step();
        read_byte(1'b1, d);  chk("R8 released after nack", d, 8'hFF);
        bus_stop();

        // R9: wrap past the last register
        q = '{8'h11, 8'h22, 8'h33};
        write_seq(8'h0E, q, "R9 wrap write");
        chk("R9 register 0 after wrap", reg_out[7:0], 8'h33);

        // R6: set hold mode mid-transfer; following bytes share one register
        q = '{8'h01, 8'h55, 8'h66};
        write_seq(8'h0A, q, "R6 hold write");
        chk("R6 register 11", reg_out[11*8 +: 8], 8'h66);
        chk("R6 register 12 untouched", reg_out[12*8 +: 8], 8'h00);
        read_seq(8'h0B, 2, "R6 hold read");

        // R12: repeated start after a held write reads the same register
        bus_start();
        send_byte(8'h54, a); chk("R12 address ack", {7'd0, a}, 8'd1);
        send_byte(8'h05, a); chk("R12 pointer ack", {7'd0, a}, 8'd1);
        send_byte(8'h77, a); chk("R12 data ack", {7'd0, a}, 8'd1);
        mreg[5] = 8'h77;
        mptr = 5;
        bus_start();
        send_byte(8'h55, a); chk("R12 read address ack", {7'd0, a}, 8'd1);
        read_byte(1'b0, d);  chk("R12 read after repeated start", d, 8'h77);
        bus_stop();
        chk_regs("R12 register contents");

        // R5: clear mode (old mode is hold), then stepping read
        q = '{8'h00};
        write_seq(8'h0A, q, "R5 clear mode");
        read_seq(8'h00, 2, "R5 step read");

        finish_run();
    end

endmodule